// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is a synchronous slave for a byte-wide memory of `2**ADDR_W` locations, 512 by default, held in on-chip registers. A host reaches it over a four-wire serial bus in clock-polarity-0, clock-phase-0 fashion. A system clock `clk` oversamples chip select, serial clock and serial data in. Those inputs must already be synchronous to `clk`, and each serial-clock half period must last at least one `clk` cycle. The block decodes a small command set:

- set the write-enable latch;
- read and write the status byte;
- streaming read;
- streaming write.

Reads and writes stream any number of bytes, and the internal address steps forward after every byte. No page buffer exists, so each written byte lands in the array as soon as its last bit arrives.

Writes are gated by three things: the write-enable latch, a write-protect input, and a two-bit protect field in the status byte that locks the top quarter, the top half or the whole array. A hold input can freeze a transfer in mid-flight. While the hold is in force the serial clock and data may toggle freely and are ignored, and the transfer later resumes where it stopped. The serial output comes as a data bit plus a drive enable, so the host side of the chip can three-state the pin.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset the drive enable is low, the write-enable latch is clear and the protect field is 00, so a status read returns 00h.
- R2: Opcode 06h sets the write-enable latch, which reads back as status bit 1.
- R3: A read opcode is 0000_A011 and a write opcode is 0000_A010, with address bit 8 in bit 3 of the opcode. One address byte follows the opcode, and every byte moves MSB first. Data is sampled on the rising serial-clock edge, and the output changes on the falling edge.
- R4: After each data byte of a burst the address increments, and it wraps from 1FFh to 000h. A burst may run for any length.
- R5: A written byte is stored right after its eighth bit. A byte cut short by chip select rising is discarded.
- R6: The rising chip-select edge that ends a write frame or a status-write frame clears the write-enable latch. With the latch clear, no array or status write takes effect.
- R7: With the latch set and write-protect low, every array location and the status byte are locked.
- R8: With the latch set and write-protect high, the status field in bits 3:2 locks a region: 00 none, 01 addresses 180h–1FFh, 10 addresses 100h–1FFh, 11 all. All other locations accept writes.
- R9: The write-protect level is taken at the first bit of each byte, so a change partway through a byte acts only from the next byte.
- R10: A low hold input taken while the serial clock is low freezes the transfer, and serial-clock edges are ignored until the hold input rises again while the serial clock is low. The transfer then continues without loss.
- R11: The drive enable is low while chip select is high, during the opcode and address bytes, and during a hold.
- R12: An opcode outside the command set is ignored until chip select rises. The array and the status byte stay unchanged.
- R13: Opcode 05h returns the status byte {0000, protect[1:0], latch, 0} for as many bytes as are clocked. Opcode 01h loads bits 3:2 of the next byte into the protect field, subject to R6 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial bus |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; its rising edge ends a frame |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in, sampled on the rising serial-clock edge |
| wpN | input | 1 | Active-low write protect |
| holdN | input | 1 | Active-low hold; changes only while the serial clock is low |
| so | output | 1 | Serial data out, updated on the falling serial-clock edge |
| soOe | output | 1 | Drive enable for the serial data out pin |

## Verification
The bench builds the block at the default address width of 9 bits, so the real 512-byte array, the 1FFh-to-000h wrap and the exact locked regions are all in play. Each serial-clock half period lasts one system clock, which makes a burst across the whole array cheap. Every protect setting is therefore checked against an arithmetically computed pattern at all 512 addresses, and a burst that starts mid-array is read back across the wrap. Hold, partial bytes, mid-byte write-protect changes and stray opcodes are then checked at single addresses against a model memory kept in the bench.

// File: rtl/spi_fram_pkg.sv
package spi_fram_pkg;

  localparam logic [7:0] OP_SETWEL = 8'h06;
  localparam logic [7:0] OP_STATRD = 8'h05;
  localparam logic [7:0] OP_STATWR = 8'h01;
  localparam logic [2:0] TAIL_RD   = 3'b011;
  localparam logic [2:0] TAIL_WR   = 3'b010;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_WDATA, PH_RDATA, PH_SWR, PH_SRD, PH_SKIP
  } phase_t;

  typedef struct packed {
    logic latchHi;
    logic latchLo;
    logic commitMem;
    logic commitStat;
    logic latchWp;
    logic incAddr;
    logic loadMem;
    logic loadStat;
    logic shiftOut;
    logic setWel;
    logic clrWel;
    logic clrOut;
  } strobes_t;

endpackage

// File: rtl/spi_fram_ctl.sv
module spi_fram_ctl
  import spi_fram_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     sck,
  input  logic     si,
  input  logic     holdN,
  output strobes_t stb,
  output logic [7:0] rxByte,
  output phase_t   phase,
  output logic     holdActive
);

  logic       sckPrev, csPrev;
  logic [2:0] bitCnt;
  logic [6:0] rxSh;
  logic       rdFrame, wrFrame;
  logic       sckRise, sckFall;
  phase_t     nextPhase;
  logic       setRd, setWr;

  always_comb begin
    sckRise   = !csN && !holdActive && sck && !sckPrev;
    sckFall   = !csN && !holdActive && !sck && sckPrev;
    rxByte    = {rxSh, si};
    stb       = '0;
    nextPhase = phase;
    setRd     = 1'b0;
    setWr     = 1'b0;
    if (csN) begin
      stb.clrOut = 1'b1;
      stb.clrWel = !csPrev && wrFrame;
      nextPhase  = PH_OPC;
    end else begin
      if (sckRise) begin
        unique case (phase)
          PH_OPC: if (bitCnt == 3'd7) begin
            if (rxByte == OP_SETWEL) begin
              stb.setWel = 1'b1;
              nextPhase  = PH_SKIP;
            end else if (rxByte == OP_STATRD) begin
              nextPhase = PH_SRD;
            end else if (rxByte == OP_STATWR) begin
              setWr     = 1'b1;
              nextPhase = PH_SWR;
            end else if (rxByte[7:4] == 4'h0 && rxByte[2:0] == TAIL_RD) begin
              stb.latchHi = 1'b1;
              setRd       = 1'b1;
              nextPhase   = PH_ADDR;
            end else if (rxByte[7:4] == 4'h0 && rxByte[2:0] == TAIL_WR) begin
              stb.latchHi = 1'b1;
              setWr       = 1'b1;
              nextPhase   = PH_ADDR;
            end else begin
              nextPhase = PH_SKIP;
            end
          end
          PH_ADDR: if (bitCnt == 3'd7) begin
            stb.latchLo = 1'b1;
            nextPhase   = rdFrame ? PH_RDATA : PH_WDATA;
          end
          PH_WDATA: begin
            stb.latchWp = (bitCnt == 3'd0);
            if (bitCnt == 3'd7) begin
              stb.commitMem = 1'b1;
              stb.incAddr   = 1'b1;
            end
          end
          PH_RDATA: stb.incAddr = (bitCnt == 3'd7);
          PH_SWR: begin
            stb.latchWp = (bitCnt == 3'd0);
            if (bitCnt == 3'd7) begin
              stb.commitStat = 1'b1;
              nextPhase      = PH_SKIP;
            end
          end
          default: ;
        endcase
      end
      if (sckFall && (phase == PH_RDATA || phase == PH_SRD)) begin
        stb.loadMem  = (bitCnt == 3'd0) && (phase == PH_RDATA);
        stb.loadStat = (bitCnt == 3'd0) && (phase == PH_SRD);
        stb.shiftOut = (bitCnt != 3'd0);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev    <= 1'b0;
      csPrev     <= 1'b1;
      holdActive <= 1'b0;
      bitCnt     <= '0;
      rxSh       <= '0;
      phase      <= PH_OPC;
      rdFrame    <= 1'b0;
      wrFrame    <= 1'b0;
    end else begin
      sckPrev <= sck;
      csPrev  <= csN;
      phase   <= nextPhase;
      if (csN)       holdActive <= 1'b0;
      else if (!sck) holdActive <= !holdN;
      if (csN)          bitCnt <= '0;
      else if (sckRise) bitCnt <= bitCnt + 3'd1;
      if (sckRise) rxSh <= rxByte[6:0];
      if (csN) begin
        rdFrame <= 1'b0;
        wrFrame <= 1'b0;
      end else begin
        if (setRd) rdFrame <= 1'b1;
        if (setWr) wrFrame <= 1'b1;
      end
    end
  end

  // R10: a held transfer keeps its bit position and phase
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(holdActive) && !$past(csN) |-> $stable(bitCnt) && $stable(phase))
    else $error("hold did not freeze the transfer");

endmodule

// File: rtl/spi_fram_dp.sv
module spi_fram_dp
  import spi_fram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   stb,
  input  logic [7:0] rxByte,
  input  logic       wpN,
  output logic       so,
  output logic       outOn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr;
  logic              hiBit, wel, wpByte;
  logic [1:0]        prot;
  logic [7:0]        txSh;
  logic              inProt, memOk, statOk;
  logic [7:0]        statusByte;

  always_comb begin
    unique case (prot)
      2'b00:   inProt = 1'b0;
      2'b01:   inProt = (addr[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   inProt = addr[ADDR_W-1];
      default: inProt = 1'b1;
    endcase
    statOk     = wel && wpByte;
    memOk      = statOk && !inProt;
    statusByte = {4'b0000, prot, wel, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (stb.commitMem && memOk) mem[addr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr   <= '0;
      hiBit  <= 1'b0;
      wel    <= 1'b0;
      wpByte <= 1'b0;
      prot   <= 2'b00;
      txSh   <= '0;
      outOn  <= 1'b0;
    end else begin
      if (stb.latchHi) hiBit <= rxByte[3];
      if (stb.latchLo)      addr <= ADDR_W'({hiBit, rxByte});
      else if (stb.incAddr) addr <= addr + ADDR_W'(1);
      if (stb.clrWel)      wel <= 1'b0;
      else if (stb.setWel) wel <= 1'b1;
      if (stb.latchWp) wpByte <= wpN;
      if (stb.commitStat && statOk) prot <= rxByte[3:2];
      if (stb.loadMem)       txSh <= mem[addr];
      else if (stb.loadStat) txSh <= statusByte;
      else if (stb.shiftOut) txSh <= {txSh[6:0], 1'b0};
      if (stb.clrOut) outOn <= 1'b0;
      else if (stb.loadMem || stb.loadStat) outOn <= 1'b1;
    end
  end

  assign so = txSh[7];

  // R6: the frame-end clear always leaves the latch low
  p_wel_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrWel |=> !wel)
    else $error("write-enable latch survived frame end");

  // R4: the top address steps to zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAddr && !stb.latchLo && (&addr) |=> addr == '0)
    else $error("address did not wrap");

  // R7: a status write with protect low leaves the field alone
  p_stat_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitStat && !wpByte |=> $stable(prot))
    else $error("status changed under write protect");

endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave
  import spi_fram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic wpN,
  input  logic holdN,
  output logic so,
  output logic soOe
);

  strobes_t   stb;
  logic [7:0] rxByte;
  phase_t     phase;
  logic       holdActive;
  logic       outOn;

  spi_fram_ctl i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .sck        (sck),
    .si         (si),
    .holdN      (holdN),
    .stb        (stb),
    .rxByte     (rxByte),
    .phase      (phase),
    .holdActive (holdActive)
  );

  spi_fram_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rxByte (rxByte),
    .wpN    (wpN),
    .so     (so),
    .outOn  (outOn)
  );

  assign soOe = outOn && !holdActive;

  // R11: no drive once chip select has been high a full cycle
  p_hiz_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    csN && $past(csN) |-> !soOe)
    else $error("output driven while deselected");

  // R11: no drive in the opcode and address bytes
  p_hiz_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OPC || phase == PH_ADDR) |-> !soOe)
    else $error("output driven during command bytes");

endmodule

// File: tb/test_spi_fram_slave.sv
`timescale 1ns/100ps
module test_spi_fram_slave;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic wpN = 1'b1, holdN = 1'b1;
  logic so, soOe;
  int   nChk = 0, nFail = 0;
  bit   done = 1'b0, oeSeen = 1'b0;
  logic [7:0] expMem [512];

  always #2.5 clk = ~clk;

  spi_fram_slave i_spi_fram_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .wpN(wpN), .holdN(holdN), .so(so), .soOe(soOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 29 + s * 71 + (a >> 4) * 3) & 255);
  endfunction

  function automatic bit locked(input int p, input int a);
    case (p)
      0: return 1'b0;
      1: return a >= 384;
      2: return a >= 256;
      default: return 1'b1;
    endcase
  endfunction

  task automatic xferBits(input logic [7:0] tx, input int hi, input int lo,
                          inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk); sck = 1'b0; si = tx[i];
      @(negedge clk); rx[i] = so; if (soOe) oeSeen = 1'b1; sck = 1'b1;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = '0;
    xferBits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic csStart();
    @(negedge clk); csN = 1'b0;
    @(negedge clk);
  endtask

  task automatic csEnd();
    @(negedge clk); sck = 1'b0;
    @(negedge clk); csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic head(input bit isRd, input int a);
    logic [7:0] d;
    xfer({4'b0000, 1'(a >> 8), 2'b01, isRd}, d);
    xfer(8'(a), d);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    csStart(); xfer(op, d); csEnd();
  endtask

  task automatic statRead(output logic [7:0] s);
    logic [7:0] d;
    csStart(); xfer(8'h05, d); xfer(8'h00, s); csEnd();
  endtask

  task automatic statWrite(input logic [7:0] v);
    logic [7:0] d;
    csStart(); xfer(8'h01, d); xfer(v, d); csEnd();
  endtask

  task automatic writeBurst(input int a, input int n, input int s);
    logic [7:0] d;
    csStart(); head(1'b0, a);
    for (int i = 0; i < n; i++) xfer(pat((a + i) % 512, s), d);
    csEnd();
  endtask

  task automatic readCheck(input int a, input int n, input string req);
    logic [7:0] d;
    csStart(); oeSeen = 1'b0; head(1'b1, a);
    chk(!oeSeen, "R11", "drive during command bytes", oeSeen, 0);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      chk(d == expMem[(a + i) % 512], req, $sformatf("read @%0h", (a + i) % 512),
          d, expMem[(a + i) % 512]);
    end
    csEnd();
    chk(!soOe, "R11", "drive after deselect", soOe, 0);
  endtask

  task automatic holdPause(input bit reading);
    @(negedge clk); sck = 1'b0;
    @(negedge clk); holdN = 1'b0;
    repeat (2) @(negedge clk);
    if (reading) chk(!soOe, "R11", "drive during hold", soOe, 0);
    repeat (3) begin
      sck = 1'b1; si = ~si; @(negedge clk);
      sck = 1'b0; @(negedge clk);
    end
    holdN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(!soOe, "R1", "drive enable after reset", soOe, 0);
    statRead(s);
    chk(s == 8'h00, "R1", "status after reset", s, 8'h00);

    // R2 latch set
    cmd1(8'h06);
    statRead(s);
    chk(s == 8'h02, "R2", "status after set-latch", s, 8'h02);

    // R3 R4 R5: full-array burst from 100h, read back across the wrap
    writeBurst(9'h100, 512, 1);
    for (int a = 0; a < 512; a++) expMem[a] = pat(a, 1);
    statRead(s);
    chk(s == 8'h00, "R6", "latch after write frame", s, 8'h00);
    readCheck(9'h0A5, 512, "R4");

    // R6 write without latch
    writeBurst(9'h010, 1, 9);
    readCheck(9'h010, 1, "R6");

    // R5 partial byte dropped
    cmd1(8'h06);
    csStart(); head(1'b0, 9'h020); xfer(8'h5A, d);
    xferBits(8'hA5, 7, 3, d);
    csEnd();
    expMem[9'h020] = 8'h5A;
    readCheck(9'h020, 2, "R5");

    // R7 protect low blocks array and status
    wpN = 1'b0;
    cmd1(8'h06);
    writeBurst(9'h030, 1, 5);
    readCheck(9'h030, 1, "R7");
    cmd1(8'h06);
    statWrite(8'h0C);
    statRead(s);
    chk(s == 8'h00, "R7", "status under write protect", s, 8'h00);
    wpN = 1'b1;

    // R8 R13 sweep of every protect setting over the whole array
    for (int p = 0; p < 4; p++) begin
      cmd1(8'h06);
      statWrite(8'(p << 2));
      statRead(s);
      chk(s == 8'(p << 2), "R13", "protect field readback", s, p << 2);
      cmd1(8'h06);
      writeBurst(0, 512, p + 2);
      for (int a = 0; a < 512; a++) if (!locked(p, a)) expMem[a] = pat(a, p + 2);
      readCheck(0, 512, "R8");
    end
    cmd1(8'h06);
    statWrite(8'h00);
    statRead(s);
    chk(s == 8'h00, "R13", "protect cleared", s, 8'h00);

    // R9 protect change partway through a byte
    cmd1(8'h06);
    csStart(); head(1'b0, 9'h040);
    xferBits(8'h11, 7, 4, d); wpN = 1'b0; xferBits(8'h11, 3, 0, d);
    xfer(8'h22, d);
    csEnd();
    wpN = 1'b1;
    expMem[9'h040] = 8'h11;
    readCheck(9'h040, 2, "R9");
    cmd1(8'h06);
    wpN = 1'b0;
    csStart(); head(1'b0, 9'h050);
    xferBits(8'h33, 7, 4, d); wpN = 1'b1; xferBits(8'h33, 3, 0, d);
    xfer(8'h44, d);
    csEnd();
    expMem[9'h051] = 8'h44;
    readCheck(9'h050, 2, "R9");

    // R10 hold inside a write and inside a read
    cmd1(8'h06);
    csStart(); head(1'b0, 9'h060);
    xferBits(8'h9C, 7, 4, d); holdPause(1'b0); xferBits(8'h9C, 3, 0, d);
    xfer(8'h3E, d);
    csEnd();
    expMem[9'h060] = 8'h9C; expMem[9'h061] = 8'h3E;
    readCheck(9'h060, 2, "R10");
    csStart(); head(1'b1, 9'h060);
    d = '0;
    xferBits(8'h00, 7, 5, d); holdPause(1'b1); xferBits(8'h00, 4, 0, d);
    chk(d == 8'h9C, "R10", "read byte across hold", d, 8'h9C);
    xfer(8'h00, d);
    chk(d == 8'h3E, "R10", "read byte after hold", d, 8'h3E);
    csEnd();

    // R12 stray opcode does nothing
    cmd1(8'h06);
    csStart(); oeSeen = 1'b0;
    xfer(8'h42, d); xfer(8'h00, d); xfer(8'h55, d); xfer(8'h55, d);
    chk(!oeSeen, "R12", "drive after stray opcode", oeSeen, 0);
    csEnd();
    statRead(s);
    chk(s == 8'h02, "R12", "status after stray opcode", s, 8'h02);
    readCheck(9'h000, 4, "R12");
    readCheck(9'h055, 1, "R12");
    csStart(); xfer(8'h02, d); csEnd();
    statRead(s);
    chk(s == 8'h00, "R6", "latch after empty write frame", s, 8'h00);

    done = 1'b1;
    report();
    $finish;
  end

endmodule